// File: doc/BRIEF.md
# FIFO Output Stage

This block is the extraction end of a fall-through FIFO. When the lowest stack slot holds a word and the consumer raises the transfer request, the word is copied into an output register and the stack is told to release it. The held word is available on a parallel bus with its own output enable, and is also streamed one bit per falling edge of a sampled shift clock on a serial output that turns itself on while a word is valid. A status flag marks whether the register holds a word that may be taken.

The transfer request is a level, not an edge: a word that arrives while the request is already high is still taken, but only one word is taken per high period, and dropping the request marks the word as consumed while the parallel bus keeps showing it. A serial consumer keeps the request high and lets the shifter empty the register after the last bit, which lets the next word in. For arrays, a slice can act as a slave: a slave that has loaded a word keeps its flag low until a permission input from its neighbour is seen, while a master raises it at once. Master or slave role is strapped through an input sampled during reset. Three-state pins are modelled as data plus enable.

Top module: `fifo_out_stage`

## Requirements
- R1: In the cycle after reset is released, `ore`, `ser_q_en` and `stk_pop` are all low.
- R2: While the register is empty, `xfer_par` is high, `xfer_inhibit` is low and `stk_valid` is high, `stk_pop` is high in that same cycle; after the next clock edge `par_q` equals the popped word and, on a master slice, `ore` is high.
- R3: While a word is held and `xfer_par` stays high, no further word is loaded and `stk_pop` stays low, even with `stk_valid` high.
- R4: When `xfer_par` is sampled low while a word is held, `ore` is low after that edge and `par_q` keeps the last word.
- R5: A high pulse on `xfer_par` while `stk_valid` is low leaves `ore` and `stk_pop` low.
- R6: With `xfer_inhibit` high no load takes place and `stk_pop` stays low.
- R7: While `ore` is high, `ser_q_en` is high and `ser_q` shows bit 0 of the word first; each falling edge of `shift_clk` (high in one sampled cycle, low in the next) moves the next higher bit onto `ser_q` after that edge.
- R8: The falling edge that shifts out the last of the W bits empties the register: `ore` and `ser_q_en` go low, and a new word may be loaded while `xfer_par` is still high.
- R9: A slice whose `chain_in_n` was high during reset (slave) keeps `ore` low after a load until `grant_in` is sampled high; a slice with `chain_in_n` low during reset (master) raises `ore` on the edge that loads.
- R10: `par_q_en` follows `par_oe` in the same cycle.
- R11: Falling edges of `shift_clk` while `ore` is low leave the held word on `par_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chain_in_n | input | 1 | Role strap sampled during reset: low makes a master, high a slave |
| grant_in | input | 1 | Permission from the neighbour for a slave to raise its flag |
| stk_valid | input | 1 | Lowest stack slot holds a word |
| stk_word | input | W | Word in the lowest stack slot |
| stk_pop | output | 1 | Release the lowest stack word (high in the cycle of an accepted load) |
| xfer_par | input | 1 | Level-sensitive transfer request |
| xfer_inhibit | input | 1 | High blocks loads (tie to a neighbour's flag in arrays, low alone) |
| shift_clk | input | 1 | Sampled serial shift clock, active on its falling edge |
| par_oe | input | 1 | Parallel output enable |
| par_q | output | W | Held word |
| par_q_en | output | 1 | Drive enable for `par_q` |
| ser_q | output | 1 | Serial data bit |
| ser_q_en | output | 1 | Drive enable for `ser_q` |
| ore | output | 1 | High while a valid, permitted word is held |

## Verification
The word path is tried with a request pulse over an empty stack, a held request across several cycles with the stack kept full, a request blocked by the inhibit input, and a release of the request; together these separate a level-sensitive load from an edge-triggered one and show that a held request cannot load a second word. A serial run with a non-symmetric word and the request kept high tells bit order apart and shows the self-emptying after the last shift followed by an immediate reload. A slice strapped as slave is loaded with and without the permission input, which separates the two interlock roles, and shift edges given to an empty register show they cannot disturb the held word.

// File: rtl/fo_pkg.sv
package fo_pkg;
  parameter int unsigned FO_DEF_W = 4;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_WAIT  = 2'd1,
    ST_VALID = 2'd2
  } fo_state_e;
endpackage

// File: rtl/fo_fall_det.sv
module fo_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;

  // R7: a falling edge needs a high sample first, so two in a row cannot occur
  p_fall_single_r7: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/fo_load_ctl.sv
module fo_load_ctl
  import fo_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic chain_in_n,
  input  logic grant_i,
  input  logic top_i,
  input  logic inhibit_i,
  input  logic stk_valid_i,
  input  logic done_i,
  output logic ld_o,
  output logic ore_o
);
  fo_state_e state_q, state_d;
  logic      master_q;

  // role strap is captured only while reset is asserted
  always_ff @(posedge clk) begin
    if (rst) master_q <= ~chain_in_n;
  end

  assign ld_o  = !rst && (state_q == ST_EMPTY) && top_i && !inhibit_i && stk_valid_i;
  assign ore_o = (state_q == ST_VALID);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_EMPTY: if (ld_o) state_d = (master_q || grant_i) ? ST_VALID : ST_WAIT;
      ST_WAIT: begin
        if (!top_i)       state_d = ST_EMPTY;
        else if (grant_i) state_d = ST_VALID;
      end
      ST_VALID: if (!top_i || done_i) state_d = ST_EMPTY;
      default: state_d = ST_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_EMPTY;
    else     state_q <= state_d;
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (state_q == ST_EMPTY));

  p_single_load_r3: assert property (@(posedge clk) disable iff (rst)
    ld_o |=> !ld_o);

  p_release_empties_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_EMPTY && !top_i) |=> (state_q == ST_EMPTY));

  p_slave_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (ld_o && !master_q && !grant_i) |=> !ore_o);

  p_last_shift_empties_r8: assert property (@(posedge clk) disable iff (rst)
    done_i |=> !ore_o);
endmodule

// File: rtl/fo_shift_reg.sv
module fo_shift_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_i,
  input  logic [W-1:0] ld_word_i,
  input  logic         shift_i,
  output logic [W-1:0] word_o,
  output logic         done_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  word_q;
  logic [CW-1:0] cnt_q;

  // data is deliberately left out of reset: only control state is cleared
  always_ff @(posedge clk) begin
    if (ld_i)         word_q <= ld_word_i;
    else if (shift_i) word_q <= {1'b0, word_q[W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst || ld_i)  cnt_q <= '0;
    else if (shift_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign word_o = word_q;
  assign done_o = shift_i && (cnt_q == LAST);

  p_word_stable_r11: assert property (@(posedge clk) disable iff (rst)
    (!ld_i && !shift_i) |=> $stable(word_q));

  p_load_takes_word_r2: assert property (@(posedge clk) disable iff (rst)
    ld_i |=> (word_q == $past(ld_word_i)));
endmodule

// File: rtl/fifo_out_stage.sv
module fifo_out_stage #(
  parameter int unsigned W = fo_pkg::FO_DEF_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         chain_in_n,
  input  logic         grant_in,
  input  logic         stk_valid,
  input  logic [W-1:0] stk_word,
  output logic         stk_pop,
  input  logic         xfer_par,
  input  logic         xfer_inhibit,
  input  logic         shift_clk,
  input  logic         par_oe,
  output logic [W-1:0] par_q,
  output logic         par_q_en,
  output logic         ser_q,
  output logic         ser_q_en,
  output logic         ore
);
  logic         fall;
  logic         ld;
  logic         shift;
  logic         done;
  logic [W-1:0] word;

  fo_fall_det u_fall (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (shift_clk),
    .fall_o (fall)
  );

  fo_load_ctl u_ctl (
    .clk         (clk),
    .rst         (rst),
    .chain_in_n  (chain_in_n),
    .grant_i     (grant_in),
    .top_i       (xfer_par),
    .inhibit_i   (xfer_inhibit),
    .stk_valid_i (stk_valid),
    .done_i      (done),
    .ld_o        (ld),
    .ore_o       (ore)
  );

  assign shift = fall && ore;

  fo_shift_reg #(.W(W)) u_sr (
    .clk       (clk),
    .rst       (rst),
    .ld_i      (ld),
    .ld_word_i (stk_word),
    .shift_i   (shift),
    .word_o    (word),
    .done_o    (done)
  );

  assign stk_pop  = ld;
  assign par_q    = word;
  assign par_q_en = par_oe;
  assign ser_q    = word[0];
  assign ser_q_en = ore;

  p_pop_then_flag_r2: assert property (@(posedge clk) disable iff (rst)
    (stk_pop && !chain_in_n && u_ctl.master_q) |=> ore);

  p_no_pop_inhibited_r6: assert property (@(posedge clk) disable iff (rst)
    xfer_inhibit |-> !stk_pop);
endmodule

// File: tb/fifo_out_stage_test.sv
module fifo_out_stage_test;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         chain_in_n = 1'b0;
  logic         grant_in = 1'b0;
  logic         stk_valid = 1'b0;
  logic [W-1:0] stk_word = '0;
  logic         stk_pop;
  logic         xfer_par = 1'b0;
  logic         xfer_inhibit = 1'b0;
  logic         shift_clk = 1'b0;
  logic         par_oe = 1'b0;
  logic [W-1:0] par_q;
  logic         par_q_en;
  logic         ser_q;
  logic         ser_q_en;
  logic         ore;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q[$];
  logic ore_prev = 1'b0;

  always #2 clk = ~clk;

  fifo_out_stage #(.W(W)) uut (
    .clk(clk), .rst(rst), .chain_in_n(chain_in_n), .grant_in(grant_in),
    .stk_valid(stk_valid), .stk_word(stk_word), .stk_pop(stk_pop),
    .xfer_par(xfer_par), .xfer_inhibit(xfer_inhibit), .shift_clk(shift_clk),
    .par_oe(par_oe), .par_q(par_q), .par_q_en(par_q_en),
    .ser_q(ser_q), .ser_q_en(ser_q_en), .ore(ore)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  // driver side of the scoreboard: a word expected to appear on a flag rise
  task automatic expect_word(input logic [W-1:0] w);
    exp_q.push_back(w);
  endtask

  // monitor: every rise of the flag must present the next expected word (R2)
  always @(negedge clk) begin
    if (!rst) begin
      if (ore && !ore_prev) begin
        if (exp_q.size() == 0) chk("R2 unexpected word", 32'(par_q), 32'hFFFF);
        else chk("R2 scoreboard word", 32'(par_q), 32'(exp_q.pop_front()));
      end
      ore_prev = ore;
    end else begin
      ore_prev = 1'b0;
    end
  end

  task automatic shift_once();
    shift_clk = 1'b1;
    nxt();
    shift_clk = 1'b0;
    nxt();
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] sw;
    // master reset
    repeat (3) nxt();
    rst = 1'b0;
    settle();
    chk("R1 ore", 32'(ore), 0);
    chk("R1 ser_q_en", 32'(ser_q_en), 0);
    chk("R1 stk_pop", 32'(stk_pop), 0);

    // R10 output enable
    nxt(); par_oe = 1'b1; settle();
    chk("R10 oe high", 32'(par_q_en), 1);
    nxt(); par_oe = 1'b0; settle();
    chk("R10 oe low", 32'(par_q_en), 0);
    nxt(); par_oe = 1'b1;

    // R5 request pulse without data
    xfer_par = 1'b1; settle();
    chk("R5 no pop", 32'(stk_pop), 0);
    nxt(); settle();
    chk("R5 ore low", 32'(ore), 0);
    nxt(); xfer_par = 1'b0; nxt(); settle();
    chk("R5 ore after pulse", 32'(ore), 0);

    // R2 / R3 level request with stack kept full
    nxt(); stk_valid = 1'b1; stk_word = 4'hA; xfer_par = 1'b1;
    expect_word(4'hA);
    settle();
    chk("R2 pop on load", 32'(stk_pop), 1);
    nxt(); stk_word = 4'h5; settle();
    chk("R2 ore master", 32'(ore), 1);
    chk("R3 no second pop", 32'(stk_pop), 0);
    nxt(); settle();
    chk("R3 still one word", 32'(par_q), 32'hA);
    chk("R3 no pop later", 32'(stk_pop), 0);

    // R4 release of the request
    nxt(); xfer_par = 1'b0; stk_valid = 1'b0;
    nxt(); settle();
    chk("R4 ore low", 32'(ore), 0);
    chk("R4 word kept", 32'(par_q), 32'hA);

    // second parallel word: request raised before data arrives
    nxt(); xfer_par = 1'b1;
    nxt(); stk_valid = 1'b1; stk_word = 4'h5; expect_word(4'h5);
    settle();
    chk("R2 late data pop", 32'(stk_pop), 1);
    nxt(); stk_valid = 1'b0; xfer_par = 1'b0;
    nxt(); settle();
    chk("R4 second release", 32'(ore), 0);

    // R6 inhibit
    nxt(); xfer_inhibit = 1'b1; xfer_par = 1'b1; stk_valid = 1'b1; stk_word = 4'h3;
    settle();
    chk("R6 no pop", 32'(stk_pop), 0);
    nxt(); settle();
    chk("R6 ore low", 32'(ore), 0);
    chk("R6 word kept", 32'(par_q), 32'h5);

    // R7 / R8 serial run with request held high
    sw = 4'b1101;
    nxt(); xfer_inhibit = 1'b0; stk_word = sw; expect_word(sw);
    settle();
    chk("R7 serial load pop", 32'(stk_pop), 1);
    nxt(); stk_valid = 1'b0; settle();
    chk("R7 ser_q_en", 32'(ser_q_en), 1);
    chk("R7 bit0", 32'(ser_q), 32'(sw[0]));
    for (int k = 1; k < W; k++) begin
      shift_once();
      settle();
      chk("R7 next bit", 32'(ser_q), 32'(sw[k]));
      chk("R7 still valid", 32'(ore), 1);
    end
    shift_once();
    settle();
    chk("R8 ore empty", 32'(ore), 0);
    chk("R8 ser off", 32'(ser_q_en), 0);
    nxt(); stk_valid = 1'b1; stk_word = 4'h6; expect_word(4'h6);
    settle();
    chk("R8 reload pop", 32'(stk_pop), 1);
    nxt(); stk_valid = 1'b0; settle();
    chk("R8 reload ore", 32'(ore), 1);

    // R11 shifts while empty
    nxt(); xfer_par = 1'b0;
    nxt(); settle();
    chk("R11 empty", 32'(ore), 0);
    shift_once();
    shift_once();
    settle();
    chk("R11 word kept", 32'(par_q), 32'h6);

    // R9 slave slice
    nxt(); rst = 1'b1; chain_in_n = 1'b1;
    nxt(); nxt(); rst = 1'b0;
    nxt(); xfer_par = 1'b1; stk_valid = 1'b1; stk_word = 4'h9; expect_word(4'h9);
    settle();
    chk("R9 slave pop", 32'(stk_pop), 1);
    nxt(); stk_valid = 1'b0; settle();
    chk("R9 slave waits", 32'(ore), 0);
    nxt(); settle();
    chk("R9 slave still waits", 32'(ore), 0);
    nxt(); grant_in = 1'b1;
    nxt(); settle();
    chk("R9 slave granted", 32'(ore), 1);
    nxt(); grant_in = 1'b0; xfer_par = 1'b0;
    nxt(); nxt(); settle();
    chk("R2 scoreboard drained", 32'(exp_q.size()), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule